// File: doc/BRIEF.md
# Lockable Security Control Register

This block holds a 32-bit security control word behind a small word-wide register bus. A companion lock register has five sticky bits, and each one freezes a fixed group of control fields. After a group is frozen, control writes leave it untouched while the remaining fields still follow the written data. A third, write-only location takes an unlock key. The correct key turns on the partial-reconfiguration path and all three decrypt-enable bits. Any other key clears those bits and shuts the whole register block until the next reset.

The control word is driven out on `ctrl_value` for the security logic around the block. `access_en` reports whether the register block still answers the bus. `decrypt_warn` flags a decrypt-enable field that is neither all zero nor all one. Only full-word accesses are honoured, so every byte strobe must be set.

Top module: `seccfg_reg`

## Requirements
- R1: After reset the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), the lock register is zero and `access_en` is 1.
- R2: The control word is at byte offset 0x00, the lock register at 0x04 and the unlock key at 0x08. A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after it is accepted. The unlock location and unmapped offsets read as zero, and writes to unmapped offsets change nothing.
- R3: Bit 31 of the control word (force reset) ignores writes and always reads 0.
- R4: A lock write ORs data bits 4:0 into the lock register, so a set lock bit stays set until reset. Lock bits 31:5 read as zero.
- R5: Lock bit 0 freezes control bits 6:0 (debug and debug-port enables), bit 1 freezes bit 7 (secure enable), bit 2 freezes bit 8 (upset-detection enable), bit 3 freezes bits 11:9 (decrypt enable) and bit 4 freezes bit 12 (key-fuse select). On a control write, frozen bits keep their value and all other writable bits take the new data.
- R6: Writing 0x757BDF0D to the unlock location sets control bit 27 and bits 11:9, whatever the lock state, and leaves every other bit as it was.
- R7: Writing any other value to the unlock location clears control bit 27 and bits 11:9 and drops `access_en` to 0.
- R8: While `access_en` is 0, every read returns zero and every write, including one carrying the correct key, is dropped until the next reset.
- R9: `decrypt_warn` is 1 exactly when control bits 11:9 hold a value other than 000 or 111.
- R10: An access with any byte strobe clear is dropped if it is a write and returns zero if it is a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte strobes; all four set for an accepted access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| ctrl_value | output | 32 | Current control word |
| access_en | output | 1 | Register block still reachable from the bus |
| decrypt_warn | output | 1 | Decrypt-enable field is inconsistent |

## Verification
The embedded properties assume at most one access per cycle, with `bus_sel`, `bus_write`, `bus_addr` and `bus_be` free of unknown values whenever the block is out of reset. They also assume the lock state seen at a write is the state before that write, so a lock update and a control write never coincide. The stimulus meets this by driving each access for exactly one cycle on the falling edge and by settling every write before it issues the next access. Reset is held across several edges so the internal synchroniser releases cleanly.

// File: rtl/seccfg_pkg.sv
package seccfg_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BE_W     = WORD_W / 8;
  localparam int unsigned LOCK_W   = 5;
  localparam int unsigned DEC_LSB  = 9;
  localparam int unsigned DEC_W    = 3;

  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0C00_6000;
  localparam logic [WORD_W-1:0] FORCE_MASK = 32'h8000_0000;
  localparam logic [WORD_W-1:0] PR_MASK    = 32'h0800_0000;
  localparam logic [WORD_W-1:0] DEC_MASK   = 32'h0000_0E00;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_LOCK   = 2'd2,
    SEL_UNLOCK = 2'd3
  } reg_sel_e;

  // Control bits frozen by each lock bit.
  function automatic logic [WORD_W-1:0] lock_group_mask(input int unsigned grp);
    logic [WORD_W-1:0] m;
    case (grp)
      0:       m = 32'h0000_007F;
      1:       m = 32'h0000_0080;
      2:       m = 32'h0000_0100;
      3:       m = DEC_MASK;
      4:       m = 32'h0000_1000;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/seccfg_rst_sync.sv
module seccfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/seccfg_decode.sv
module seccfg_decode
  import seccfg_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]  CTRL_OFFS   = 'h00,
  parameter logic [ADDR_W-1:0]  LOCK_OFFS   = 'h04,
  parameter logic [ADDR_W-1:0]  UNLOCK_OFFS = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic              access_en,
  output logic              wr_ctrl,
  output logic              wr_lock,
  output logic              wr_unlock,
  output logic              rd_go,
  output reg_sel_e          rd_sel
);

  logic     full_word;
  logic     open_acc;
  reg_sel_e hit;

  assign full_word = &bus_be;
  assign open_acc  = bus_sel && full_word && access_en;

  always_comb begin
    hit = SEL_NONE;
    if (bus_addr == CTRL_OFFS) begin
      hit = SEL_CTRL;
    end else if (bus_addr == LOCK_OFFS) begin
      hit = SEL_LOCK;
    end else if (bus_addr == UNLOCK_OFFS) begin
      hit = SEL_UNLOCK;
    end
  end

  always_comb begin
    wr_ctrl   = 1'b0;
    wr_lock   = 1'b0;
    wr_unlock = 1'b0;
    rd_sel    = SEL_NONE;
    rd_go     = bus_sel && !bus_write;
    if (open_acc) begin
      if (bus_write) begin
        wr_ctrl   = (hit == SEL_CTRL);
        wr_lock   = (hit == SEL_LOCK);
        wr_unlock = (hit == SEL_UNLOCK);
      end else begin
        rd_sel    = hit;
      end
    end
  end

  AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !(&bus_be)) |-> !(wr_ctrl || wr_lock || wr_unlock) && (rd_sel == SEL_NONE)); // R10

  AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !access_en |-> !(wr_ctrl || wr_lock || wr_unlock)); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_ctrl, wr_lock, wr_unlock}) <= 1); // R2

endmodule

// File: rtl/seccfg_lock.sv
module seccfg_lock
  import seccfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic [LOCK_W-1:0] wdata_lock,
  output logic [LOCK_W-1:0] lock_q
);

  logic [LOCK_W-1:0] lock_d;
  logic              lock_en;

  assign lock_en = wr_lock;

  always_comb begin
    lock_d = lock_q | wdata_lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (~lock_q & $past(lock_q)) == '0); // R4

endmodule

// File: rtl/seccfg_ctrl.sv
module seccfg_ctrl
  import seccfg_pkg::*;
#(
  parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_unlock,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LOCK_W-1:0] lock_q,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              access_q
);

  localparam logic [WORD_W-1:0] KEY_SET = PR_MASK | DEC_MASK;

  logic [WORD_W-1:0] grp_keep [LOCK_W];
  logic [WORD_W-1:0] keep_mask;
  logic [WORD_W-1:0] ctrl_d;
  logic              access_d;
  logic              ctrl_en;
  logic              access_en_ff;
  logic              key_ok;

  genvar g;
  generate
    for (g = 0; g < LOCK_W; g++) begin : g_grp
      localparam logic [WORD_W-1:0] GMASK = lock_group_mask(g);
      assign grp_keep[g] = lock_q[g] ? GMASK : '0;

      AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q[g] && !wr_unlock) |=> $stable(ctrl_q & GMASK)); // R5
    end
  endgenerate

  always_comb begin
    keep_mask = '0;
    for (int i = 0; i < LOCK_W; i++) begin
      keep_mask = keep_mask | grp_keep[i];
    end
  end

  assign key_ok       = (wdata == UNLOCK_KEY);
  assign ctrl_en      = wr_ctrl || wr_unlock;
  assign access_en_ff = wr_unlock;

  always_comb begin
    ctrl_d   = ctrl_q;
    access_d = access_q;
    if (wr_ctrl) begin
      ctrl_d = ((wdata & ~keep_mask) | (ctrl_q & keep_mask)) & ~FORCE_MASK;
    end else if (wr_unlock) begin
      if (key_ok) begin
        ctrl_d = ctrl_q | KEY_SET;
      end else begin
        ctrl_d   = ctrl_q & ~KEY_SET;
        access_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_q <= 1'b1;
    end else if (access_en_ff) begin
      access_q <= access_d;
    end
  end

  AST_GOOD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unlock && wdata == UNLOCK_KEY) |=> ((ctrl_q & KEY_SET) == KEY_SET) && access_q); // R6

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unlock && wdata != UNLOCK_KEY) |=> ((ctrl_q & KEY_SET) == '0) && !access_q); // R7

  AST_STAY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !access_q |=> !access_q && $stable(ctrl_q)); // R8

  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !ctrl_q[WORD_W-1]); // R3

endmodule

// File: rtl/seccfg_reg.sv
module seccfg_reg
  import seccfg_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]  CTRL_OFFS   = 'h00,
  parameter logic [ADDR_W-1:0]  LOCK_OFFS   = 'h04,
  parameter logic [ADDR_W-1:0]  UNLOCK_OFFS = 'h08,
  parameter logic [31:0]        UNLOCK_KEY  = 32'h757B_DF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [31:0]       ctrl_value,
  output logic              access_en,
  output logic              decrypt_warn
);

  logic              rst_sync_n;
  logic              wr_ctrl;
  logic              wr_lock;
  logic              wr_unlock;
  logic              rd_go;
  reg_sel_e          rd_sel;
  logic [LOCK_W-1:0] lock_q;
  logic [WORD_W-1:0] ctrl_q;
  logic              access_q;
  logic [WORD_W-1:0] rdata_d;
  logic [WORD_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [DEC_W-1:0]  dec_field;

  seccfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seccfg_decode #(
    .ADDR_W      (ADDR_W),
    .CTRL_OFFS   (CTRL_OFFS),
    .LOCK_OFFS   (LOCK_OFFS),
    .UNLOCK_OFFS (UNLOCK_OFFS)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .access_en (access_q),
    .wr_ctrl   (wr_ctrl),
    .wr_lock   (wr_lock),
    .wr_unlock (wr_unlock),
    .rd_go     (rd_go),
    .rd_sel    (rd_sel)
  );

  seccfg_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_lock    (wr_lock),
    .wdata_lock (bus_wdata[LOCK_W-1:0]),
    .lock_q     (lock_q)
  );

  seccfg_ctrl #(
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_ctrl   (wr_ctrl),
    .wr_unlock (wr_unlock),
    .wdata     (bus_wdata),
    .lock_q    (lock_q),
    .ctrl_q    (ctrl_q),
    .access_q  (access_q)
  );

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rdata_d = ctrl_q;
      SEL_LOCK: rdata_d = {{(WORD_W-LOCK_W){1'b0}}, lock_q};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rd_go) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
    end
  end

  assign dec_field    = ctrl_q[DEC_LSB +: DEC_W];
  assign decrypt_warn = (dec_field != '0) && (dec_field != '1);
  assign bus_rdata    = rdata_q;
  assign bus_rvalid   = rvalid_q;
  assign ctrl_value   = ctrl_q;
  assign access_en    = access_q;

  AST_CLOSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_go && !access_q) |=> (bus_rdata == '0)); // R8

  AST_LOCK_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rvalid |-> (bus_rdata[WORD_W-1] == 1'b0)); // R3

endmodule

// File: tb/sim_seccfg_reg.sv
module sim_seccfg_reg;

  localparam logic [31:0] KEY = 32'h757B_DF0D;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_write;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] ctrl_value;
  logic        access_en;
  logic        decrypt_warn;

  int          total;
  int          bad;
  bit          done;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  seccfg_reg u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rvalid   (bus_rvalid),
    .ctrl_value   (ctrl_value),
    .access_en    (access_en),
    .decrypt_warn (decrypt_warn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read data as each response appears.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R2 unexpected read response actual=%08h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_be = 4'hF; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ctrl_value", ctrl_value, 32'h0C00_6000);
    check("R1 access_en", {31'b0, access_en}, 32'd1);
    rd(8'h00, 32'h0C00_6000, "R1 ctrl read");
    rd(8'h04, 32'h0, "R1 lock read");
    // R2 unlock and unmapped read zero
    rd(8'h08, 32'h0, "R2 unlock reads zero");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R2 unmapped read");
    check("R2 unmapped write no effect", ctrl_value, 32'h0C00_6000);

    // R3 force bit ignored
    wr(8'h00, 32'hFFFF_FFFF);
    check("R3 force bit", ctrl_value, 32'h7FFF_FFFF);
    rd(8'h00, 32'h7FFF_FFFF, "R3 ctrl read");
    check("R9 warn with 111", {31'b0, decrypt_warn}, 32'd0);

    // R9 inconsistent decrypt field
    wr(8'h00, 32'h0000_0200);
    check("R9 warn with 001", {31'b0, decrypt_warn}, 32'd1);
    wr(8'h00, 32'h0000_0A00);
    check("R9 warn with 101", {31'b0, decrypt_warn}, 32'd1);
    wr(8'h00, 32'h0);
    check("R9 warn with 000", {31'b0, decrypt_warn}, 32'd0);

    // R5 debug group locked
    wr(8'h04, 32'h0000_0001);
    wr(8'h00, 32'hFFFF_FFFF);
    check("R5 debug group frozen", ctrl_value, 32'h7FFF_FF80);
    rd(8'h04, 32'h0000_0001, "R4 lock read");
    // R4 sticky OR
    wr(8'h04, 32'h0000_0004);
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0000_0005, "R4 lock sticky");
    wr(8'h00, 32'h0);
    check("R5 upset bit frozen", ctrl_value, 32'h0000_0100);
    // R4 all bits, upper zero
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_001F, "R4 lock upper zero");
    wr(8'h00, 32'h0FFF_FFFF);
    check("R5 all groups frozen", ctrl_value, 32'h0FFF_E100);

    // R10 partial accesses
    wr(8'h00, 32'h0, 4'h3);
    check("R10 partial write dropped", ctrl_value, 32'h0FFF_E100);
    rd(8'h00, 32'h0, "R10 partial read zero", 4'h7);
    wr(8'h08, 32'h1234_5678, 4'hE);
    check("R10 partial unlock dropped", {31'b0, access_en}, 32'd1);

    // R6 good key overrides decrypt lock
    wr(8'h00, 32'h0);
    check("R5 upper bits writable", ctrl_value, 32'h0000_0100);
    wr(8'h08, KEY);
    check("R6 good key", ctrl_value, 32'h0800_0F00);
    check("R6 access kept", {31'b0, access_en}, 32'd1);

    // R7 bad key
    wr(8'h08, 32'h1234_5678);
    check("R7 bad key clears", ctrl_value, 32'h0000_0100);
    check("R7 access closed", {31'b0, access_en}, 32'd0);
    check("R9 warn after clear", {31'b0, decrypt_warn}, 32'd0);

    // R8 closed block
    rd(8'h00, 32'h0, "R8 closed ctrl read");
    rd(8'h04, 32'h0, "R8 closed lock read");
    wr(8'h00, 32'hFFFF_FFFF);
    check("R8 closed write dropped", ctrl_value, 32'h0000_0100);
    wr(8'h08, KEY);
    check("R8 key ignored when closed", {31'b0, access_en}, 32'd0);
    check("R8 ctrl after key", ctrl_value, 32'h0000_0100);

    // R1 second reset reopens
    do_reset();
    check("R1 reopen access", {31'b0, access_en}, 32'd1);
    check("R1 reopen ctrl", ctrl_value, 32'h0C00_6000);
    rd(8'h04, 32'h0, "R1 lock cleared");

    repeat (3) @(negedge clk);
    check("R2 all reads answered", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule